// File: doc/BRIEF.md
# Dual-Read Register File with Write-Protected Entries

This block holds the general-purpose registers of a single-cycle processor datapath: 32 entries of 32 bits. Two read ports each take a 5-bit index and return the selected entry combinationally. One write port takes a 5-bit index, 32-bit data and an enable from the control unit, and stores on the rising clock edge. A read of an entry during the cycle that writes it returns the old contents.

Three entries are write-protected: index 0, index 26 and index 27. They always hold zero. A write aimed at any of them is dropped without changing anything. The attempt is reported through a single-cycle flag. A synchronous active-high reset returns every entry to zero.

Top module: `prot_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every entry is cleared to zero and `prot_hit` goes low. After reset, every index reads zero on both ports.
- R2: When `wr_en` is 1 and `wr_idx` is unprotected, the entry at `wr_idx` takes `wr_data` at the rising edge. A later write to the same index overwrites the earlier value.
- R3: When `wr_en` is 0, no entry changes at the edge, whatever the values of `wr_idx` and `wr_data`.
- R4: Index 0 always reads zero, including after a write aimed at it.
- R5: Indices 26 and 27 always read zero, including after writes aimed at them.
- R6: Read port A and read port B each return the entry selected by their own index, independently of each other. When both select the same entry, both return the same value.
- R7: Reads are combinational. In the cycle of a write, a read of the target index returns the value held before the write.
- R8: `prot_hit` is 1 for exactly the one cycle that follows an edge at which `wr_en` was 1 and `wr_idx` was 0, 26 or 27. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | 5 | Index for read port A |
| rd_idx_b | input | 5 | Index for read port B |
| wr_en | input | 1 | Write enable from the control unit |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Value to write |
| rd_data_a | output | 32 | Contents of entry `rd_idx_a` |
| rd_data_b | output | 32 | Contents of entry `rd_idx_b` |
| prot_hit | output | 1 | One-cycle pulse after a dropped write to a protected entry |

## Verification
The vector table interleaves enabled writes to ordinary entries with writes aimed at indices 0, 26 and 27. A protected entry that stores data therefore reads nonzero, and a protected write that leaks into a neighbouring entry changes a value the table has recorded. Some rows read the entry being written in the same cycle, which separates a combinational read of the old value from a forwarded one. Other rows read the same entry on both ports, or mismatched entries, to expose crossed read ports. Rows with the enable low but a live-looking index and data show whether the enable gates both the store and the flag. Directed tests then check reset in the middle of traffic and confirm that the flag lasts a single cycle.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int NUM_REGS = 32;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);

    // Bit i set means entry i is write-protected and pinned to zero.
    localparam logic [NUM_REGS-1:0] PROT_MASK = (NUM_REGS'(1) << 0)
                                              | (NUM_REGS'(1) << 26)
                                              | (NUM_REGS'(1) << 27);

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    function automatic logic is_protected(input idx_t idx);
        return PROT_MASK[idx];
    endfunction
endpackage

// File: rtl/rf_write_filter.sv
module rf_write_filter
    import regfile_pkg::*;
(
    input  wr_req_t             req,
    output logic [NUM_REGS-1:0] sel,
    output logic                blocked
);
    logic prot;

    always_comb begin
        prot    = is_protected(req.idx);
        blocked = req.en && prot;
        sel     = '0;
        if (req.en && !prot) begin
            sel[req.idx] = 1'b1;
        end
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] sel,
    input  word_t               data,
    output word_t               q [NUM_REGS]
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        if (PROT_MASK[i]) begin : g_pinned
            // A pinned entry returns to zero on any select.
            always_ff @(posedge clk) begin
                if (rst || sel[i]) begin
                    q[i] <= '0;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[i] <= '0;
                end else if (sel[i]) begin
                    q[i] <= data;
                end
            end
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
(
    input  word_t entries [NUM_REGS],
    input  idx_t  idx,
    output word_t data
);
    assign data = entries[idx];
endmodule

// File: rtl/prot_regfile.sv
module prot_regfile
    import regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_idx_a,
    input  logic [4:0]  rd_idx_b,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data_a,
    output logic [31:0] rd_data_b,
    output logic        prot_hit
);
    wr_req_t             req;
    logic [NUM_REGS-1:0] sel;
    logic                blocked;
    word_t               entries [NUM_REGS];

    assign req = '{en: wr_en, idx: wr_idx, data: wr_data};

    rf_write_filter u_filter (
        .req     (req),
        .sel     (sel),
        .blocked (blocked)
    );

    rf_storage u_store (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel),
        .data (req.data),
        .q    (entries)
    );

    rf_read_port u_rd_a (.entries(entries), .idx(rd_idx_a), .data(rd_data_a));
    rf_read_port u_rd_b (.entries(entries), .idx(rd_idx_b), .data(rd_data_b));

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_hit <= 1'b0;
        end else begin
            prot_hit <= blocked;
        end
    end
endmodule

// File: rtl/prot_regfile_checker.sv
module prot_regfile_checker
    import regfile_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [4:0]  rd_idx_a,
    input logic [4:0]  rd_idx_b,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data_a,
    input logic [31:0] rd_data_b,
    input logic        prot_hit
);
    a_r1_reset_clears_flag: assert property (@(posedge clk)
        rst |=> !prot_hit);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_protected(wr_idx)) |=>
            ((rd_idx_a != $past(wr_idx)) || (rd_data_a == $past(wr_data))));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!$stable(rd_idx_b) || $stable(rd_data_b)));

    a_r4_zero_entry: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == 5'd0) |-> (rd_data_a == 32'd0));

    a_r5_pinned_entries: assert property (@(posedge clk) disable iff (rst)
        ((rd_idx_b == 5'd26) || (rd_idx_b == 5'd27)) |-> (rd_data_b == 32'd0));

    a_r6_same_index_same_value: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b));

    a_r8_flag_on_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_protected(wr_idx)) |=> prot_hit);

    a_r8_flag_quiet: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && is_protected(wr_idx)) |=> !prot_hit);
endmodule

bind prot_regfile prot_regfile_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_idx_a  (rd_idx_a),
    .rd_idx_b  (rd_idx_b),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .prot_hit  (prot_hit)
);

// File: tb/prot_regfile_tb.sv
module prot_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic        prot_hit;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prot_regfile u_dut (
        .clk(clk), .rst(rst), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .prot_hit(prot_hit)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  widx;
        logic [31:0] wdata;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] exp_a;   // read values before this row's edge
        logic [31:0] exp_b;
        logic        exp_hit; // flag after this row's edge
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd0,  32'h0,          32'h0,          1'b0}, // R7
        '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd5,  5'd0,  32'hA5A5_0001, 32'h0,          1'b1}, // R2 R8
        '{1'b1, 5'd26, 32'h1234_5678, 5'd0,  5'd5,  32'h0,          32'hA5A5_0001, 1'b1}, // R4
        '{1'b1, 5'd27, 32'h8765_4321, 5'd26, 5'd5,  32'h0,          32'hA5A5_0001, 1'b1}, // R5
        '{1'b0, 5'd7,  32'hDEAD_BEEF, 5'd27, 5'd26, 32'h0,          32'h0,          1'b0}, // R5
        '{1'b1, 5'd31, 32'hCAFE_0031, 5'd7,  5'd5,  32'h0,          32'hA5A5_0001, 1'b0}, // R3
        '{1'b1, 5'd1,  32'h0000_0011, 5'd31, 5'd31, 32'hCAFE_0031, 32'hCAFE_0031, 1'b0}, // R6
        '{1'b1, 5'd5,  32'h5555_0005, 5'd1,  5'd5,  32'h0000_0011, 32'hA5A5_0001, 1'b0}, // R7
        '{1'b0, 5'd0,  32'h0,         5'd5,  5'd1,  32'h5555_0005, 32'h0000_0011, 1'b0}, // R2
        '{1'b0, 5'd26, 32'h0000_FFFF, 5'd0,  5'd26, 32'h0,          32'h0,          1'b0}  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: every entry reads zero after reset
        for (int i = 0; i < 32; i++) begin
            rd_idx_a = 5'(i);
            rd_idx_b = 5'(31 - i);
            #0.5;
            check("R1 port A", rd_data_a, 32'h0);
            check("R1 port B", rd_data_b, 32'h0);
        end
        check("R1 flag", {31'h0, prot_hit}, 32'h0);

        // Vector table
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            wr_en    = VECS[v].we;
            wr_idx   = VECS[v].widx;
            wr_data  = VECS[v].wdata;
            rd_idx_a = VECS[v].ra;
            rd_idx_b = VECS[v].rb;
            #1;
            check("R6/R7 port A", rd_data_a, VECS[v].exp_a);
            check("R6/R7 port B", rd_data_b, VECS[v].exp_b);
            @(negedge clk);
            check("R8 flag", {31'h0, prot_hit}, {31'h0, VECS[v].exp_hit});
        end

        // R8: the pulse lasts a single cycle
        wr_en = 1'b1; wr_idx = 5'd27; wr_data = 32'h0BAD_0BAD;
        @(negedge clk);
        check("R8 pulse", {31'h0, prot_hit}, 32'h1);
        wr_en = 1'b0;
        @(negedge clk);
        check("R8 one cycle", {31'h0, prot_hit}, 32'h0);
        rd_idx_a = 5'd27;
        #0.5;
        check("R5 entry 27", rd_data_a, 32'h0);

        // R1: reset in the middle of traffic, with a protected write pending
        wr_en = 1'b1; wr_idx = 5'd0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        check("R1 flag under reset", {31'h0, prot_hit}, 32'h0);
        rd_idx_a = 5'd5; rd_idx_b = 5'd31;
        #0.5;
        check("R1 entry 5 cleared", rd_data_a, 32'h0);
        check("R1 entry 31 cleared", rd_data_b, 32'h0);

        // R2: a write after reset lands again
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd31; wr_data = 32'h7777_1234;
        @(negedge clk);
        wr_en = 1'b0;
        #0.5;
        check("R2 rewrite after reset", rd_data_b, 32'h7777_1234);

        finish_run();
    end
endmodule